// File: doc/BRIEF.md
# Clock Generator Configuration Sequencer

This block brings an external programmable clock generator from one configuration to another by driving a byte-wide register-access port. A separate serial bus master carries out each access. On a start pulse it runs a fixed sequence of steps. It first silences every clock output and writes an unlock value. It then streams a configuration image from a small ROM-like port, where each entry holds a register address, a value and a write mask. After the image it pulses the device's soft reset. When down-spread operation is selected, it also holds the divider reset for one millisecond. Its last step turns the outputs back on.

Every write that changes only some bits is a read-modify-write. The block reads the register, merges it as `(old & ~mask) | (new & mask)`, and writes the result back. An entry whose mask is all ones is written directly, with no read. If an access reports an error, the sequencer leaves out the remaining steps and raises an error flag. It still attempts to re-enable the outputs. A one-cycle done pulse closes every run, whether it succeeded or not.

Top module: `clkgen_cfg_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o` and `acc_req_o` are all 0.
- R2: The first write of a run goes to register 230 (0xE6) with bit 4 set and its other bits as read back from the device.
- R3: The second write puts 0x65 into register 241 (0xF1), and register 241 is never read.
- R4: Image entries are applied in index order 0 to IMG_LEN-1. Each entry leaves its register at `(old & ~mask) | (value & mask)`, where `img_addr_i`, `img_val_i` and `img_mask_i` are the address, value and mask of entry `img_idx_o`.
- R5: An image entry whose mask is 0xFF is written without a read of its register. An entry with any other mask is read exactly once.
- R6: After the last image write, register 246 (0xF6) is written with bit 1 set and its other bits preserved.
- R7: When `spread_i` is 1 at start, register 226 (0xE2) is written with bit 2 set and later with bit 2 cleared. The two writes are at least CLK_HZ/1000 cycles apart, and other bits are preserved. When `spread_i` is 0, register 226 is not accessed.
- R8: The last write of every run goes to register 230 with bit 4 cleared and its other bits preserved.
- R9: `busy_o` is 1 from the cycle after an accepted start until the run completes. `done_o` is then high for exactly one cycle, during which `busy_o` is 0.
- R10: A start pulse while `busy_o` is 1 has no effect on the run in progress.
- R11: An access answered with `acc_err_i` = 1 ends the run early. `err_o` is raised, no further image, soft-reset or divider-reset step is performed, and the closing write of R8 is still made. `err_o` stays 1 until the next accepted start clears it.
- R12: `acc_req_o` is only 1 while busy. Once raised, it stays 1 with stable `acc_we_o`, `acc_addr_o` and `acc_wdata_o` until `acc_ack_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse; accepted only when idle |
| spread_i | input | 1 | Selects the divider-reset step (down-spread), sampled at start |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| err_o | output | 1 | Last run was aborted by an access error |
| img_idx_o | output | IDX_W | Index of the image entry being read |
| img_addr_i | input | 8 | Register address of the entry |
| img_val_i | input | 8 | Value of the entry |
| img_mask_i | input | 8 | Write-allowed mask of the entry |
| acc_req_o | output | 1 | Register access request, held until acknowledged |
| acc_we_o | output | 1 | 1 = write, 0 = read |
| acc_addr_o | output | 8 | Register address |
| acc_wdata_o | output | 8 | Write data |
| acc_ack_i | input | 1 | One-cycle completion of the current access |
| acc_rdata_i | input | 8 | Read data, valid with the acknowledge |
| acc_err_i | input | 1 | Access failed (for example not acknowledged on the bus) |

## Verification
The bench targets the masked merge with its two extremes. A mask of 0xFF must skip the read, and a mask of 0x00 must leave the register as it was. A design that merged the wrong way round, or that always read, would show up in the final register contents and in the read counts. The bench times the gap between the two divider-reset writes to catch a timer that ends early, or a step that runs when spread is off. It also injects an error on one image register. This exposes a sequencer that carries on with the soft reset, or that never turns the outputs back on. A second start during a run tests whether a restart would duplicate writes.

// File: rtl/cfg_seq_pkg.sv
// Package: shared constants and types for the clock generator configuration
// sequencer. Register addresses and bit positions are fixed by the device.
package cfg_seq_pkg;

    localparam int unsigned REG_AW = 8;
    localparam int unsigned REG_DW = 8;

    localparam logic [REG_AW-1:0] REG_OUT_CTRL = 8'd230;
    localparam int unsigned       OUT_OFF_BIT  = 4;
    localparam logic [REG_AW-1:0] REG_UNLOCK   = 8'd241;
    localparam logic [REG_DW-1:0] UNLOCK_VAL   = 8'h65;
    localparam logic [REG_AW-1:0] REG_SOFT_RST = 8'd246;
    localparam int unsigned       SOFT_RST_BIT = 1;
    localparam logic [REG_AW-1:0] REG_DIV_RST  = 8'd226;
    localparam int unsigned       DIV_RST_BIT  = 2;

    // One register update: address, new value, bits that may change.
    typedef struct packed {
        logic [REG_AW-1:0] addr;
        logic [REG_DW-1:0] val;
        logic [REG_DW-1:0] mask;
    } reg_op_t;

    // Sequence steps in execution order.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OUT_OFF,
        ST_UNLOCK,
        ST_LOAD,
        ST_SOFT_RST,
        ST_DIV_SET,
        ST_DIV_WAIT,
        ST_DIV_CLR,
        ST_OUT_ON
    } step_e;

    // Access engine phases.
    typedef enum logic [1:0] {
        EN_IDLE,
        EN_READ,
        EN_WRITE
    } eng_e;

endpackage

// File: rtl/cfg_rmw_engine.sv
// Module: cfg_rmw_engine
// Performs one masked register update over the request/acknowledge access
// port. Reads first and merges unless the mask is all ones.
// Assumes: op_start_i arrives only when the engine is idle; the access port
// acknowledges each request with a one-cycle acc_ack_i.
module cfg_rmw_engine
    import cfg_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start_i,
    input  reg_op_t           op_i,
    output logic              op_done_o,
    output logic              op_err_o,
    output logic              acc_req_o,
    output logic              acc_we_o,
    output logic [REG_AW-1:0] acc_addr_o,
    output logic [REG_DW-1:0] acc_wdata_o,
    input  logic              acc_ack_i,
    input  logic [REG_DW-1:0] acc_rdata_i,
    input  logic              acc_err_i
);

    eng_e              phase_q;
    reg_op_t           op_q;
    logic [REG_DW-1:0] wdata_q;
    logic              done_q;
    logic              err_q;

    // Phase sequencing, operand capture, merge and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= EN_IDLE;
            op_q    <= '0;
            wdata_q <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (phase_q)
                EN_IDLE: begin
                    if (op_start_i) begin
                        op_q <= op_i;
                        if (&op_i.mask) begin
                            wdata_q <= op_i.val;
                            phase_q <= EN_WRITE;
                        end else begin
                            phase_q <= EN_READ;
                        end
                    end
                end
                EN_READ: begin
                    if (acc_ack_i) begin
                        if (acc_err_i) begin
                            done_q  <= 1'b1;
                            err_q   <= 1'b1;
                            phase_q <= EN_IDLE;
                        end else begin
                            wdata_q <= (acc_rdata_i & ~op_q.mask) |
                                       (op_q.val & op_q.mask);
                            phase_q <= EN_WRITE;
                        end
                    end
                end
                EN_WRITE: begin
                    if (acc_ack_i) begin
                        done_q  <= 1'b1;
                        err_q   <= acc_err_i;
                        phase_q <= EN_IDLE;
                    end
                end
                default: phase_q <= EN_IDLE;
            endcase
        end
    end

    assign acc_req_o   = (phase_q != EN_IDLE);
    assign acc_we_o    = (phase_q == EN_WRITE);
    assign acc_addr_o  = op_q.addr;
    assign acc_wdata_o = wdata_q;
    assign op_done_o   = done_q;
    assign op_err_o    = err_q;

endmodule

// File: rtl/cfg_wait_timer.sv
// Module: cfg_wait_timer
// One-shot delay: a load pulse starts a count of WAIT_CYC cycles, after
// which expire_o pulses for one cycle.
// Assumes: WAIT_CYC >= 1; load_i is not repeated while counting.
module cfg_wait_timer #(
    parameter int unsigned WAIT_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expire_o
);

    localparam int unsigned CNT_W = $clog2(WAIT_CYC + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             exp_q;

    // Count down from the load and flag the final cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
            exp_q <= 1'b0;
        end else begin
            exp_q <= 1'b0;
            if (load_i) begin
                cnt_q <= CNT_W'(WAIT_CYC);
                run_q <= 1'b1;
            end else if (run_q) begin
                if (cnt_q == CNT_W'(1)) begin
                    run_q <= 1'b0;
                    exp_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign expire_o = exp_q;

endmodule

// File: rtl/cfg_step_ctrl.sv
// Module: cfg_step_ctrl
// Walks the bring-up order: outputs off, unlock, image load, soft reset,
// optional timed divider reset, outputs on. Issues one update at a time to
// the access engine and diverts to the outputs-on step on any error.
// Assumes: IMG_LEN >= 1; the image port answers combinationally.
module cfg_step_ctrl
    import cfg_seq_pkg::*;
#(
    parameter int unsigned IMG_LEN = 16,
    parameter int unsigned IDX_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              spread_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [IDX_W-1:0]  img_idx_o,
    input  logic [REG_AW-1:0] img_addr_i,
    input  logic [REG_DW-1:0] img_val_i,
    input  logic [REG_DW-1:0] img_mask_i,
    output logic              op_start_o,
    output reg_op_t           op_o,
    input  logic              op_done_i,
    input  logic              op_err_i,
    output logic              tmr_load_o,
    input  logic              tmr_expire_i
);

    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(IMG_LEN - 1);
    localparam logic [REG_DW-1:0] OFF_MASK  = REG_DW'(1) << OUT_OFF_BIT;
    localparam logic [REG_DW-1:0] SRST_MASK = REG_DW'(1) << SOFT_RST_BIT;
    localparam logic [REG_DW-1:0] DIV_MASK  = REG_DW'(1) << DIV_RST_BIT;

    step_e            state_q;
    logic             pend_q;
    logic [IDX_W-1:0] idx_q;
    logic             spread_q;
    logic             err_q;
    logic             done_q;
    logic             op_state;

    // Steps that issue a register update (all but idle and the wait).
    assign op_state   = (state_q != ST_IDLE) && (state_q != ST_DIV_WAIT);
    assign op_start_o = op_state && !pend_q;
    assign tmr_load_o = (state_q == ST_DIV_SET) && op_done_i && !op_err_i;

    // Select the update belonging to the current step.
    always_comb begin
        case (state_q)
            ST_OUT_OFF:  op_o = '{addr: REG_OUT_CTRL, val: OFF_MASK,   mask: OFF_MASK};
            ST_UNLOCK:   op_o = '{addr: REG_UNLOCK,   val: UNLOCK_VAL, mask: '1};
            ST_LOAD:     op_o = '{addr: img_addr_i,   val: img_val_i,  mask: img_mask_i};
            ST_SOFT_RST: op_o = '{addr: REG_SOFT_RST, val: SRST_MASK,  mask: SRST_MASK};
            ST_DIV_SET:  op_o = '{addr: REG_DIV_RST,  val: DIV_MASK,   mask: DIV_MASK};
            ST_DIV_CLR:  op_o = '{addr: REG_DIV_RST,  val: '0,         mask: DIV_MASK};
            ST_OUT_ON:   op_o = '{addr: REG_OUT_CTRL, val: '0,         mask: OFF_MASK};
            default:     op_o = '0;
        endcase
    end

    // Step advance, image index, error capture and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            pend_q   <= 1'b0;
            idx_q    <= '0;
            spread_q <= 1'b0;
            err_q    <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (op_start_o) begin
                pend_q <= 1'b1;
            end
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q  <= ST_OUT_OFF;
                        err_q    <= 1'b0;
                        idx_q    <= '0;
                        spread_q <= spread_i;
                        pend_q   <= 1'b0;
                    end
                end
                ST_DIV_WAIT: begin
                    if (tmr_expire_i) begin
                        state_q <= ST_DIV_CLR;
                    end
                end
                default: begin
                    if (op_done_i) begin
                        pend_q <= 1'b0;
                        if (state_q == ST_OUT_ON) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                            if (op_err_i) begin
                                err_q <= 1'b1;
                            end
                        end else if (op_err_i) begin
                            err_q   <= 1'b1;
                            state_q <= ST_OUT_ON;
                        end else begin
                            case (state_q)
                                ST_OUT_OFF: state_q <= ST_UNLOCK;
                                ST_UNLOCK:  state_q <= ST_LOAD;
                                ST_LOAD: begin
                                    if (idx_q == LAST_IDX) begin
                                        state_q <= ST_SOFT_RST;
                                    end else begin
                                        idx_q <= idx_q + 1'b1;
                                    end
                                end
                                ST_SOFT_RST: state_q <= spread_q ? ST_DIV_SET : ST_OUT_ON;
                                ST_DIV_SET:  state_q <= ST_DIV_WAIT;
                                ST_DIV_CLR:  state_q <= ST_OUT_ON;
                                default:     state_q <= ST_IDLE;
                            endcase
                        end
                    end
                end
            endcase
        end
    end

    assign busy_o    = (state_q != ST_IDLE);
    assign done_o    = done_q;
    assign err_o     = err_q;
    assign img_idx_o = idx_q;

endmodule

// File: rtl/clkgen_cfg_seq.sv
// Module: clkgen_cfg_seq (top)
// Reprograms an external clock generator through a register-access port in
// a fixed order, with masked read-modify-write updates and an optional
// one-millisecond divider-reset pulse.
// Assumes: CLK_HZ is the system clock frequency; IMG_LEN >= 1.
module clkgen_cfg_seq #(
    parameter int unsigned CLK_HZ  = 100_000_000,
    parameter int unsigned IMG_LEN = 16,
    parameter int unsigned IDX_W   = (IMG_LEN > 1) ? $clog2(IMG_LEN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             spread_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o,
    output logic [IDX_W-1:0] img_idx_o,
    input  logic [7:0]       img_addr_i,
    input  logic [7:0]       img_val_i,
    input  logic [7:0]       img_mask_i,
    output logic             acc_req_o,
    output logic             acc_we_o,
    output logic [7:0]       acc_addr_o,
    output logic [7:0]       acc_wdata_o,
    input  logic             acc_ack_i,
    input  logic [7:0]       acc_rdata_i,
    input  logic             acc_err_i
);

    import cfg_seq_pkg::*;

    localparam int unsigned WAIT_CYC = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;

    logic    op_start;
    reg_op_t op;
    logic    op_done;
    logic    op_err;
    logic    tmr_load;
    logic    tmr_expire;

    cfg_step_ctrl #(
        .IMG_LEN (IMG_LEN),
        .IDX_W   (IDX_W)
    ) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .spread_i     (spread_i),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .err_o        (err_o),
        .img_idx_o    (img_idx_o),
        .img_addr_i   (img_addr_i),
        .img_val_i    (img_val_i),
        .img_mask_i   (img_mask_i),
        .op_start_o   (op_start),
        .op_o         (op),
        .op_done_i    (op_done),
        .op_err_i     (op_err),
        .tmr_load_o   (tmr_load),
        .tmr_expire_i (tmr_expire)
    );

    cfg_rmw_engine eng_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_start_i  (op_start),
        .op_i        (op),
        .op_done_o   (op_done),
        .op_err_o    (op_err),
        .acc_req_o   (acc_req_o),
        .acc_we_o    (acc_we_o),
        .acc_addr_o  (acc_addr_o),
        .acc_wdata_o (acc_wdata_o),
        .acc_ack_i   (acc_ack_i),
        .acc_rdata_i (acc_rdata_i),
        .acc_err_i   (acc_err_i)
    );

    cfg_wait_timer #(
        .WAIT_CYC (WAIT_CYC)
    ) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (tmr_load),
        .expire_o (tmr_expire)
    );

endmodule

// File: rtl/clkgen_cfg_seq_chk.sv
// Module: clkgen_cfg_seq_chk
// Port-level protocol checks for clkgen_cfg_seq, attached by bind.
module clkgen_cfg_seq_chk
    import cfg_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       busy_o,
    input logic       done_o,
    input logic       err_o,
    input logic       acc_req_o,
    input logic       acc_we_o,
    input logic [7:0] acc_addr_o,
    input logic [7:0] acc_wdata_o,
    input logic       acc_ack_i,
    input logic       acc_err_i
);

    // R9: done lasts one cycle and coincides with idle.
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R3: the unlock register is never read.
    a_r3_unlock_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req_o && !acc_we_o) |-> (acc_addr_o != REG_UNLOCK));

    // R12: requests only while busy, held stable until acknowledged.
    a_r12_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req_o |-> busy_o);
    a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req_o && !acc_ack_i) |=> (acc_req_o && $stable(acc_we_o) &&
                                       $stable(acc_addr_o) && $stable(acc_wdata_o)));

    // R11: an errored access raises the error flag.
    a_r11_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && acc_ack_i && acc_err_i) |-> ##2 err_o);

endmodule

bind clkgen_cfg_seq clkgen_cfg_seq_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .acc_req_o   (acc_req_o),
    .acc_we_o    (acc_we_o),
    .acc_addr_o  (acc_addr_o),
    .acc_wdata_o (acc_wdata_o),
    .acc_ack_i   (acc_ack_i),
    .acc_err_i   (acc_err_i)
);

// File: tb/clkgen_cfg_seq_tb_top.sv
// Bench: device register model on the access port, image table on the ROM
// port, checks of access order, contents, timing and handshake.
module clkgen_cfg_seq_tb_top;

    localparam int unsigned CLK_HZ  = 10_000;
    localparam int unsigned WAIT    = CLK_HZ / 1000;
    localparam int unsigned IMG_LEN = 6;
    localparam int unsigned IDX_W   = 3;

    // {addr, value, mask}
    localparam logic [23:0] IMG [0:IMG_LEN-1] = '{
        24'h1C_A3_FF, 24'h20_0F_F0, 24'h31_81_3C,
        24'h45_00_FF, 24'h50_FF_01, 24'h62_5A_00
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic spread = 1'b0;
    logic busy, done, err;
    logic [IDX_W-1:0] idx;
    logic [7:0] img_a, img_v, img_m;
    logic req, we, ack, aerr;
    logic [7:0] addr, wdata, rdata;

    always #2.5 clk = ~clk;

    clkgen_cfg_seq #(.CLK_HZ(CLK_HZ), .IMG_LEN(IMG_LEN), .IDX_W(IDX_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .spread_i(spread),
        .busy_o(busy), .done_o(done), .err_o(err), .img_idx_o(idx),
        .img_addr_i(img_a), .img_val_i(img_v), .img_mask_i(img_m),
        .acc_req_o(req), .acc_we_o(we), .acc_addr_o(addr), .acc_wdata_o(wdata),
        .acc_ack_i(ack), .acc_rdata_i(rdata), .acc_err_i(aerr)
    );

    always_comb begin
        if (int'(idx) < IMG_LEN) {img_a, img_v, img_m} = IMG[idx];
        else {img_a, img_v, img_m} = '0;
    end

    // Device model: register file, write log, read counts.
    logic [7:0] mem [0:255];
    int rd_cnt [0:255];
    logic [7:0] log_a [0:63];
    logic [7:0] log_d [0:63];
    int log_c [0:63];
    int log_n = 0;
    int cyc = 0;
    int done_cnt = 0;
    logic [7:0] err_addr = 8'h00;
    logic err_arm = 1'b0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (done) done_cnt <= done_cnt + 1;
        if (!rst_n) begin
            ack <= 1'b0; aerr <= 1'b0; rdata <= '0;
            for (int a = 0; a < 256; a++) begin
                mem[a] <= 8'(a) ^ 8'h5A;
                rd_cnt[a] <= 0;
            end
        end else begin
            ack <= 1'b0; aerr <= 1'b0;
            if (req && !ack) begin
                ack <= 1'b1;
                if (err_arm && addr == err_addr) begin
                    aerr <= 1'b1;
                end else if (we) begin
                    mem[addr] <= wdata;
                    if (log_n < 64) begin
                        log_a[log_n] <= addr; log_d[log_n] <= wdata; log_c[log_n] <= cyc;
                    end
                    log_n <= log_n + 1;
                end else begin
                    rdata <= mem[addr];
                    rd_cnt[addr] <= rd_cnt[addr] + 1;
                end
            end
        end
    end

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req_s, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req_s, act, exp);
        end
    endtask

    function automatic logic [7:0] merge(input logic [7:0] o, input logic [7:0] v, input logic [7:0] m);
        return (o & ~m) | (v & m);
    endfunction

    task automatic pulse_start(input logic sp);
        @(negedge clk); start = 1'b1; spread = sp;
        @(negedge clk); start = 1'b0; spread = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 5000) begin @(negedge clk); n++; end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int base, dc;
        logic [7:0] p230, p226, p246, p45;

        repeat (4) @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !err && !req, "R1 reset outputs", {busy, done, err, req}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // ---- Run A: no spread ----
        p230 = mem[230]; p246 = mem[246]; p226 = mem[226];
        base = log_n; dc = done_cnt;
        pulse_start(1'b0);
        chk(busy === 1'b1, "R9 busy after start", busy, 1);
        wait_done();
        chk(done && !busy, "R9 done with busy low", {done, busy}, 2);
        chk(err === 1'b0, "R11 no error on clean run", err, 0);
        @(negedge clk);
        chk(!done, "R9 done one cycle", done, 0);
        chk(log_n - base == 10, "R8 write count no spread", log_n - base, 10);
        chk(log_a[base] == 230 && log_d[base] == (p230 | 8'h10), "R2 outputs off first",
            log_d[base], p230 | 8'h10);
        chk(log_a[base+1] == 241 && log_d[base+1] == 8'h65, "R3 unlock write",
            log_d[base+1], 8'h65);
        chk(rd_cnt[241] == 0, "R3 unlock not read", rd_cnt[241], 0);
        // R4: table walk over the image
        for (int i = 0; i < IMG_LEN; i++) begin
            logic [7:0] a;
            a = IMG[i][23:16];
            chk(log_a[base+2+i] == a, "R4 image order", log_a[base+2+i], a);
            chk(mem[a] == merge(a ^ 8'h5A, IMG[i][15:8], IMG[i][7:0]), "R4 masked result",
                mem[a], merge(a ^ 8'h5A, IMG[i][15:8], IMG[i][7:0]));
            chk(rd_cnt[a] == ((IMG[i][7:0] == 8'hFF) ? 0 : 1), "R5 read count",
                rd_cnt[a], (IMG[i][7:0] == 8'hFF) ? 0 : 1);
        end
        chk(log_a[base+8] == 246 && log_d[base+8] == (p246 | 8'h02), "R6 soft reset",
            log_d[base+8], p246 | 8'h02);
        chk(rd_cnt[226] == 0 && mem[226] == p226, "R7 divider untouched no spread",
            rd_cnt[226], 0);
        chk(log_a[base+9] == 230 && log_d[base+9] == (p230 & 8'hEF), "R8 outputs on last",
            log_d[base+9], p230 & 8'hEF);
        chk(done_cnt - dc == 1, "R9 one done per run", done_cnt - dc, 1);

        // ---- Run B: spread, with a start while busy ----
        p230 = mem[230]; p226 = mem[226];
        base = log_n; dc = done_cnt;
        pulse_start(1'b1);
        repeat (15) @(negedge clk);
        pulse_start(1'b0); // R10: ignored
        wait_done();
        repeat (30) @(negedge clk);
        chk(log_n - base == 12, "R10 no restart, spread count", log_n - base, 12);
        chk(done_cnt - dc == 1, "R10 single done", done_cnt - dc, 1);
        chk(log_a[base] == 230 && log_a[base+1] == 241, "R10 order kept", log_a[base+1], 241);
        chk(log_a[base+9] == 226 && log_d[base+9] == (p226 | 8'h04), "R7 divider set",
            log_d[base+9], p226 | 8'h04);
        chk(log_a[base+10] == 226 && log_d[base+10] == (p226 & 8'hFB), "R7 divider clear",
            log_d[base+10], p226 & 8'hFB);
        chk(log_c[base+10] - log_c[base+9] >= WAIT && log_c[base+10] - log_c[base+9] <= WAIT + 10,
            "R7 divider hold time", log_c[base+10] - log_c[base+9], WAIT);
        chk(log_a[base+11] == 230 && log_d[base+11] == (p230 & 8'hEF), "R8 outputs on after spread",
            log_d[base+11], p230 & 8'hEF);

        // ---- Run C: error on image entry 2 (register 0x31) ----
        p230 = mem[230]; p246 = mem[246]; p45 = mem[8'h45];
        err_addr = 8'h31; err_arm = 1'b1;
        base = log_n;
        pulse_start(1'b1);
        wait_done();
        chk(err === 1'b1, "R11 error flag", err, 1);
        @(negedge clk);
        chk(err === 1'b1, "R11 error flag held", err, 1);
        chk(log_n - base == 5, "R11 abort write count", log_n - base, 5);
        chk(log_a[base+4] == 230 && log_d[base+4] == (p230 & 8'hEF), "R11 outputs re-enabled",
            log_d[base+4], p230 & 8'hEF);
        chk(mem[246] == p246 && mem[8'h45] == p45, "R11 later steps skipped", mem[246], p246);

        // ---- Run D: clean again, error cleared ----
        err_arm = 1'b0;
        pulse_start(1'b0);
        chk(err === 1'b0, "R11 error cleared by start", err, 0);
        wait_done();
        chk(err === 1'b0 && !busy, "R11 clean after recovery", err, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule